// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a single-cycle processor for a small subset of a 32-bit load/store instruction set with three fixed instruction layouts: register, immediate and jump. Every instruction is fetched, decoded, executed and retired in one clock cycle. Results are written into a 32-entry register file, and data memory is reached only through word loads and word stores. The core holds its own instruction memory array and its own data memory array.

The instruction array has no write port. The surrounding environment fills it before reset is released, through a hierarchical reference to `imem_q` inside the top module. Software-visible results appear only on debug ports. These ports show the register-file write that commits at the coming clock edge, the program counter of the instruction now executing, and a flag for a misaligned word access.

Top module: `rcore_top`

## Requirements
- R1: While `rst_n` is low, `dbg_pc` reads 0, and neither `dbg_wr_en` nor `align_err` is asserted. After `rst_n` rises, execution starts with the instruction word at byte address 0.
- R2: Register-layout instructions use opcode 0 with bits [31:26] = op, [25:21] = rs, [20:16] = rt, [15:11] = rd and [5:0] = funct. Funct 0x20 writes rs+rt to rd and funct 0x22 writes rs-rt to rd, both modulo 2^32.
- R3: Funct 0x2A (opcode 0) writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R4: Immediate-layout instructions use bits [15:0] as the immediate and write rt. Opcode 8 writes rs plus the sign-extended immediate. Opcode 10 writes 1 when rs is signed-less-than the sign-extended immediate, and writes 0 otherwise.
- R5: Opcode 12 writes rs AND the zero-extended immediate to rt. Opcode 13 writes rs OR the zero-extended immediate to rt.
- R6: Opcode 15 writes the immediate into rt bits [31:16] and clears bits [15:0]. A following opcode-13 instruction therefore completes a full 32-bit constant.
- R7: Register 0 always reads as zero. A write aimed at register 0 is dropped, and `dbg_wr_en` stays low for it.
- R8: Opcode 35 loads the data word at byte address rs + sign-extended immediate into rt. Opcode 43 stores rt to that address and writes no register.
- R9: An opcode 35 or 43 access whose address has bits [1:0] not equal to 0 raises `align_err` in its cycle. It writes no register, and it leaves data memory unchanged.
- R10: Opcode 4 (branch if rs equals rt) and opcode 5 (branch if they differ) set the next PC to PC+4 + (sign-extended immediate × 4) when taken, and to PC+4 when not taken.
- R11: Opcode 2 sets the next PC to {bits [31:28] of PC+4, instruction bits [25:0], 2'b00}.
- R12: Every other instruction, including unsupported opcodes, advances the PC by 4. An unsupported opcode writes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_wr_en | output | 1 | A register write commits at the next rising edge |
| dbg_wr_idx | output | 5 | Destination register of that write |
| dbg_wr_data | output | 32 | Value being written |
| dbg_pc | output | 32 | Byte address of the instruction executing this cycle |
| align_err | output | 1 | The current word access is misaligned and is suppressed |

## Verification
The debug write port, `align_err` and the next-PC logic are combinational from the current PC, so an instruction's result can be seen in the same cycle it executes. The register and PC updates land on the following rising edge. The bench drives and observes only in the low half of the clock. One nanosecond after each falling edge, it compares the PC, the write port and the error flag against a hand-computed expectation for exactly one instruction. It then waits for the next falling edge, which covers one rising edge and so one retired instruction. A load that follows a store is checked in the later cycle, because the store lands at the rising edge between the two checks.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

   localparam logic [5:0] OPC_REG  = 6'd0;
   localparam logic [5:0] OPC_JMP  = 6'd2;
   localparam logic [5:0] OPC_BEQ  = 6'd4;
   localparam logic [5:0] OPC_BNE  = 6'd5;
   localparam logic [5:0] OPC_ADDI = 6'd8;
   localparam logic [5:0] OPC_SLTI = 6'd10;
   localparam logic [5:0] OPC_ANDI = 6'd12;
   localparam logic [5:0] OPC_ORI  = 6'd13;
   localparam logic [5:0] OPC_LUI  = 6'd15;
   localparam logic [5:0] OPC_LDW  = 6'd35;
   localparam logic [5:0] OPC_STW  = 6'd43;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_SLT,
      ALU_AND,
      ALU_OR,
      ALU_UPPER
   } alu_op_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rd;
      logic    use_imm;
      logic    imm_zext;
      logic    mem_rd;
      logic    mem_wr;
      logic    br_eq;
      logic    br_ne;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
   import rcore_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl = '0;
      ctrl.alu_op = ALU_ADD;
      unique case (opcode)
         OPC_REG: begin
            ctrl.dst_rd = 1'b1;
            unique case (funct)
               FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
               FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
               FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
               default: ctrl.reg_we = 1'b0;
            endcase
         end
         OPC_ADDI: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.alu_op  = ALU_ADD;
         end
         OPC_SLTI: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.alu_op  = ALU_SLT;
         end
         OPC_ANDI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.imm_zext = 1'b1;
            ctrl.alu_op   = ALU_AND;
         end
         OPC_ORI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.imm_zext = 1'b1;
            ctrl.alu_op   = ALU_OR;
         end
         OPC_LUI: begin
            ctrl.reg_we   = 1'b1;
            ctrl.use_imm  = 1'b1;
            ctrl.imm_zext = 1'b1;
            ctrl.alu_op   = ALU_UPPER;
         end
         OPC_LDW: begin
            ctrl.reg_we  = 1'b1;
            ctrl.use_imm = 1'b1;
            ctrl.mem_rd  = 1'b1;
         end
         OPC_STW: begin
            ctrl.use_imm = 1'b1;
            ctrl.mem_wr  = 1'b1;
         end
         OPC_BEQ: ctrl.br_eq = 1'b1;
         OPC_BNE: ctrl.br_ne = 1'b1;
         OPC_JMP: ctrl.jump  = 1'b1;
         default: ctrl.reg_we = 1'b0;
      endcase
   end

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
   import rcore_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  alu_op_e         op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   output logic [XLEN-1:0] y
);

   localparam int HALF = XLEN / 2;

   logic [XLEN-1:0] sum;
   logic [XLEN-1:0] diff;
   logic            lt_signed;

   assign sum       = a + b;
   assign diff      = a - b;
   assign lt_signed = $signed(a) < $signed(b);

   always_comb begin
      unique case (op)
         ALU_ADD:   y = sum;
         ALU_SUB:   y = diff;
         ALU_SLT:   y = {{(XLEN-1){1'b0}}, lt_signed};
         ALU_AND:   y = a & b;
         ALU_OR:    y = a | b;
         ALU_UPPER: y = {b[HALF-1:0], {HALF{1'b0}}};
         default:   y = sum;
      endcase
   end

endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
   parameter int XLEN    = 32,
   parameter int REG_CNT = 32,
   localparam int IDX_W  = $clog2(REG_CNT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [XLEN-1:0]  ra_data,
   output logic [XLEN-1:0]  rb_data,
   input  logic             we,
   input  logic [IDX_W-1:0] wa_idx,
   input  logic [XLEN-1:0]  wd
);

   logic [XLEN-1:0] rf [REG_CNT];

   for (genvar i = 0; i < REG_CNT; i++) begin : g_ent
      if (i == 0) begin : g_zero
         assign rf[i] = '0;
      end else begin : g_reg
         logic [XLEN-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we && (wa_idx == IDX_W'(i)))
               q <= wd;
         end
         assign rf[i] = q;
      end
   end

   assign ra_data = rf[ra_idx];
   assign rb_data = rf[rb_idx];

   a_r7_r0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ra_idx == '0) |-> (ra_data == '0));

   a_r7_r0_reads_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
      (rb_idx == '0) |-> (rb_data == '0));

endmodule

// File: rtl/rcore_dmem.sv
module rcore_dmem #(
   parameter int XLEN  = 32,
   parameter int WORDS = 64,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_req,
   input  logic            wr_req,
   input  logic [XLEN-1:0] addr,
   input  logic [XLEN-1:0] wdata,
   output logic [XLEN-1:0] rdata,
   output logic            misalign
);

   logic [XLEN-1:0]  mem [WORDS];
   logic [IDX_W-1:0] idx;
   logic             unused_addr_bits;

   assign idx              = addr[IDX_W+1:2];
   assign unused_addr_bits = ^addr[XLEN-1:IDX_W+2];
   assign misalign         = (rd_req || wr_req) && (addr[1:0] != 2'b00);
   assign rdata            = mem[idx];

   always_ff @(posedge clk) begin
      if (wr_req && !misalign)
         mem[idx] <= wdata;
   end

   initial begin
      assert (WORDS == (1 << IDX_W)) else $fatal(1, "data memory depth must be a power of two");
   end

   a_r9_store_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && misalign) |=> (mem[$past(idx)] == $past(rdata)));

endmodule

// File: rtl/rcore_top.sv
module rcore_top
   import rcore_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          REG_CNT    = 32,
   parameter int          IMEM_WORDS = 64,
   parameter int          DMEM_WORDS = 64,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   output logic        dbg_wr_en,
   output logic [4:0]  dbg_wr_idx,
   output logic [31:0] dbg_wr_data,
   output logic [31:0] dbg_pc,
   output logic        align_err
);

   localparam int IA_W  = $clog2(IMEM_WORDS);
   localparam int IMM_W = 16;
   localparam int RI_W  = $clog2(REG_CNT);

   // Instruction store: filled from outside through a hierarchical reference.
   logic [XLEN-1:0] imem_q [IMEM_WORDS];

   initial begin
      for (int i = 0; i < IMEM_WORDS; i++) imem_q[i] = '0;
   end

   initial begin
      assert (XLEN == 32) else $fatal(1, "instruction layouts fix XLEN at 32");
      assert (REG_CNT == 32) else $fatal(1, "5-bit register fields need 32 registers");
      assert (IMEM_WORDS == (1 << IA_W)) else $fatal(1, "instruction depth must be a power of two");
      assert (RESET_PC[1:0] == 2'b00) else $fatal(1, "reset PC must be word aligned");
   end

   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt, jmp_tgt;
   logic [XLEN-1:0] instr;
   logic [5:0]      f_op, f_fn;
   logic [RI_W-1:0] f_rs, f_rt, f_rd;
   logic [IMM_W-1:0] f_imm;
   logic [25:0]     f_jaddr;
   logic            unused_bits;
   ctrl_t           ctrl;

   assign instr   = imem_q[pc_q[IA_W+1:2]];
   assign f_op    = instr[31:26];
   assign f_rs    = instr[25:21];
   assign f_rt    = instr[20:16];
   assign f_rd    = instr[15:11];
   assign f_imm   = instr[15:0];
   assign f_fn    = instr[5:0];
   assign f_jaddr = instr[25:0];
   assign unused_bits = ^{instr[10:6], pc_q[XLEN-1:IA_W+2], pc_q[1:0]};

   rcore_decode u_dec (
      .opcode (f_op),
      .funct  (f_fn),
      .ctrl   (ctrl)
   );

   logic [XLEN-1:0] rs_val, rt_val, imm_ext, alu_b, alu_y, ld_data, wr_data;
   logic [RI_W-1:0] wr_idx;
   logic            misalign, commit, take;

   assign imm_ext = ctrl.imm_zext ? {{(XLEN-IMM_W){1'b0}}, f_imm}
                                  : {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm};
   assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

   rcore_alu #(.XLEN(XLEN)) u_alu (
      .op (ctrl.alu_op),
      .a  (rs_val),
      .b  (alu_b),
      .y  (alu_y)
   );

   rcore_dmem #(.XLEN(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_req   (ctrl.mem_rd),
      .wr_req   (ctrl.mem_wr),
      .addr     (alu_y),
      .wdata    (rt_val),
      .rdata    (ld_data),
      .misalign (misalign)
   );

   assign wr_idx  = ctrl.dst_rd ? f_rd : f_rt;
   assign wr_data = ctrl.mem_rd ? ld_data : alu_y;
   assign commit  = ctrl.reg_we && !misalign && (wr_idx != '0);

   rcore_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .ra_idx  (f_rs),
      .rb_idx  (f_rt),
      .ra_data (rs_val),
      .rb_data (rt_val),
      .we      (commit),
      .wa_idx  (wr_idx),
      .wd      (wr_data)
   );

   // Next PC selection
   assign pc_plus4 = pc_q + XLEN'(4);
   assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign jmp_tgt  = {pc_plus4[XLEN-1:28], f_jaddr, 2'b00};
   assign take     = (ctrl.br_eq && (rs_val == rt_val)) ||
                     (ctrl.br_ne && (rs_val != rt_val));

   always_comb begin
      if (ctrl.jump)
         pc_next = jmp_tgt;
      else if (take)
         pc_next = br_tgt;
      else
         pc_next = pc_plus4;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pc_q <= RESET_PC;
      else
         pc_q <= pc_next;
   end

   assign dbg_wr_en   = rst_n && commit;
   assign dbg_wr_idx  = wr_idx;
   assign dbg_wr_data = wr_data;
   assign dbg_pc      = pc_q;
   assign align_err   = rst_n && misalign;

   a_r12_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.jump && !ctrl.br_eq && !ctrl.br_ne) |=> (pc_q == $past(pc_q) + 32'd4));

   a_r12_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_q[1:0] == 2'b00));

   a_r11_jump_field: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.jump |=> (pc_q[27:2] == $past(f_jaddr)));

   a_r9_no_write_on_misalign: assert property (@(posedge clk) disable iff (!rst_n)
      align_err |-> !dbg_wr_en);

endmodule

// File: tb/rcore_top_tb_top.sv
module rcore_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        dbg_wr_en;
   logic [4:0]  dbg_wr_idx;
   logic [31:0] dbg_wr_data;
   logic [31:0] dbg_pc;
   logic        align_err;

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   rcore_top dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .dbg_wr_en   (dbg_wr_en),
      .dbg_wr_idx  (dbg_wr_idx),
      .dbg_wr_data (dbg_wr_data),
      .dbg_pc      (dbg_pc),
      .align_err   (align_err)
   );

   function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   function automatic logic [31:0] enc_j(input int byte_addr);
      logic [31:0] a = byte_addr;
      return {6'd2, a[27:2]};
   endfunction

   task automatic put(input int byte_addr, input logic [31:0] w);
      dut_i.imem_q[byte_addr / 4] = w;
   endtask

   task automatic report(input bit bad, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (bad) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // One instruction per call: sample 1 ns after the falling edge, then move to the next one.
   task automatic step(input logic [31:0] epc, input logic ewe, input int eidx,
                       input logic [31:0] edata, input logic eerr, input string req);
      #1;
      report(dbg_pc !== epc, req, "pc", dbg_pc, epc);
      report(dbg_wr_en !== ewe, req, "wr_en", {31'd0, dbg_wr_en}, {31'd0, ewe});
      report(align_err !== eerr, req, "align_err", {31'd0, align_err}, {31'd0, eerr});
      if (ewe) begin
         report(dbg_wr_idx !== 5'(eidx), req, "wr_idx", {27'd0, dbg_wr_idx}, 32'(eidx));
         report(dbg_wr_data !== edata, req, "wr_data", dbg_wr_data, edata);
      end
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=completion");
      finish_run();
   end

   initial begin : stim
      rst_n = 1'b0;
      #1;
      put(0,   enc_i(8, 0, 1, 5));
      put(4,   enc_i(8, 0, 2, -3));
      put(8,   enc_r(32'h20, 1, 2, 3));
      put(12,  enc_r(32'h22, 2, 1, 4));
      put(16,  enc_r(32'h2A, 2, 1, 5));
      put(20,  enc_r(32'h2A, 1, 2, 6));
      put(24,  enc_i(10, 2, 7, -2));
      put(28,  enc_i(12, 2, 8, 32'hF0F0));
      put(32,  enc_i(13, 0, 9, 32'h8001));
      put(36,  enc_i(15, 0, 10, 32'hABCD));
      put(40,  enc_i(13, 10, 10, 32'h1234));
      put(44,  enc_r(32'h20, 1, 1, 0));
      put(48,  enc_r(32'h20, 0, 1, 11));
      put(52,  enc_i(43, 0, 10, 8));
      put(56,  enc_i(35, 0, 12, 8));
      put(60,  enc_i(43, 0, 3, 10));
      put(64,  enc_i(35, 0, 13, 9));
      put(68,  enc_i(35, 0, 13, 8));
      put(72,  enc_i(8, 0, 15, 12));
      put(76,  enc_i(35, 15, 14, -4));
      put(80,  enc_i(4, 1, 11, 2));
      put(84,  enc_i(8, 0, 20, 1));
      put(88,  enc_i(8, 0, 20, 2));
      put(92,  enc_i(5, 1, 11, 5));
      put(96,  enc_i(5, 1, 2, 1));
      put(100, enc_i(8, 0, 20, 3));
      put(104, enc_i(4, 1, 2, 7));
      put(108, enc_j(120));
      put(112, enc_i(8, 0, 21, 1));
      put(116, enc_i(8, 0, 21, 2));
      put(120, 32'hFC00_0000);
      put(124, enc_i(8, 0, 16, 32'h7FFF));
      put(128, enc_i(8, 16, 17, 1));
      put(132, enc_r(32'h20, 10, 10, 18));
      put(136, enc_j(136));

      // R1: reset state, even though the first instruction writes a register
      repeat (2) @(negedge clk);
      #1;
      report(dbg_pc !== 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
      report(dbg_wr_en !== 1'b0, "R1", "wr_en in reset", {31'd0, dbg_wr_en}, 32'd0);
      report(align_err !== 1'b0, "R1", "align_err in reset", {31'd0, align_err}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      step(0,   1, 1,  32'd5,             0, "R1");
      step(4,   1, 2,  32'(-3),           0, "R4");
      step(8,   1, 3,  32'(5 + (-3)),     0, "R2");
      step(12,  1, 4,  32'(-3 - 5),       0, "R2");
      step(16,  1, 5,  32'd1,             0, "R3");
      step(20,  1, 6,  32'd0,             0, "R3");
      step(24,  1, 7,  32'd1,             0, "R4");
      step(28,  1, 8,  32'hF0F0 & 32'(-3), 0, "R5");
      step(32,  1, 9,  32'h0000_8001,     0, "R5");
      step(36,  1, 10, 32'hABCD_0000,     0, "R6");
      step(40,  1, 10, 32'hABCD_1234,     0, "R6");
      step(44,  0, 0,  32'd0,             0, "R7");
      step(48,  1, 11, 32'd5,             0, "R7");
      step(52,  0, 0,  32'd0,             0, "R8");
      step(56,  1, 12, 32'hABCD_1234,     0, "R8");
      step(60,  0, 0,  32'd0,             1, "R9");
      step(64,  0, 0,  32'd0,             1, "R9");
      step(68,  1, 13, 32'hABCD_1234,     0, "R9");
      step(72,  1, 15, 32'd12,            0, "R4");
      step(76,  1, 14, 32'hABCD_1234,     0, "R8");
      step(80,  0, 0,  32'd0,             0, "R10");
      step(84 + 4 * 2, 0, 0, 32'd0,       0, "R10");
      step(96,  0, 0,  32'd0,             0, "R10");
      step(100 + 4 * 1, 0, 0, 32'd0,      0, "R10");
      step(108, 0, 0,  32'd0,             0, "R11");
      step(120, 0, 0,  32'd0,             0, "R12");
      step(124, 1, 16, 32'd32767,         0, "R4");
      step(128, 1, 17, 32'd32767 + 32'd1, 0, "R4");
      step(132, 1, 18, 32'(64'h0ABCD_1234 * 2), 0, "R2");
      step(136, 0, 0,  32'd0,             0, "R11");
      step(136, 0, 0,  32'd0,             0, "R11");
      step(136, 0, 0,  32'd0,             0, "R12");

      // R1: a second reset returns to address 0 and replays the first instruction
      rst_n = 1'b0;
      #1;
      report(dbg_pc !== 32'd0, "R1", "pc after re-reset", dbg_pc, 32'd0);
      report(dbg_wr_en !== 1'b0, "R1", "wr_en after re-reset", {31'd0, dbg_wr_en}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(0,   1, 1,  32'd5,             0, "R1");
      step(4,   1, 2,  32'(-3),           0, "R1");

      finish_run();
   end

endmodule